// File: doc/BRIEF.md
# UART with Word-Register Host Interface

This block is a single-channel asynchronous serial port for a 32-bit register bus. It sends and receives 8N1 frames. There are three word registers. The data word carries the byte and two handshake flags. The control word holds the interface mode, two flow-gate overrides and a sticky overrun flag. The clock-configuration word holds a scale and a step value, which are sent out to an external baud-tick generator.

To send, software writes a byte with the send strobe set. Before that it can poll the ready flag, which reads from the same word. To receive, software reads the data word, checks the valid flag and then acknowledges by writing one to that flag. The block holds one byte in each direction, plus the shift registers. Bit timing comes from a 16x oversample tick supplied from outside the block.

Top module: `uart_regif`

## Requirements
- R1: After reset, the data word (offset 0x0) reads 0x200: send-ready bit 9 is 1, valid bit 8 is 0 and the byte is 0. The control word (0x4) and the clock word (0x8) read 0. `tx_o` is high.
- R2: A write to offset 0x0 with bit 9 set, while bit 9 reads 1, queues bits [7:0] for sending. Bit 9 reads 0 on the very next cycle.
- R3: A write to offset 0x0 with bit 9 clear starts no frame. `tx_o` stays high and bit 9 keeps reading 1.
- R4: A frame on `tx_o` is one low start bit, then 8 data bits least significant first, then one high stop bit. Each bit lasts 16 `tick_i` pulses. The line idles high.
- R5: A queued byte starts only while `tx_allow_i` is 1 or control bit 7 (send override) is 1. Otherwise it waits and bit 9 keeps reading 0.
- R6: A valid frame on `rx_i` is sampled at bit centres. After the stop bit it appears in bits [7:0] of offset 0x0, with bit 8 reading 1.
- R7: Writing offset 0x0 with bit 8 set clears the valid flag. A write with bit 8 clear leaves the flag and the byte unchanged.
- R8: A frame that completes while bit 8 is 1 is dropped, and the held byte is kept. It sets sticky control bit 9 (overrun). Writing the control word with bit 9 set clears the overrun flag.
- R9: A low pulse on `rx_i` that is gone before the middle of the start bit does not start a reception. Bit 8 stays 0.
- R10: Control bits [3:2] (mode: 1 = terminal side, 2 = modem side), bit 7 and bit 8 read back as written. `rx_rdy_o` is 1 when the valid flag is 0 or control bit 8 (receive override) is 1.
- R11: The clock word stores step in bits [15:0] and scale in bits [27:16]. Bits [31:28] read 0. `clk_cfg_o` carries the same value.
- R12: Accesses to other offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 4 | Byte offset of the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| tick_i | input | 1 | 16x oversample tick |
| tx_allow_i | input | 1 | Remote side permits sending |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| rx_rdy_o | output | 1 | Local side can take a byte |
| clk_cfg_o | output | 32 | Clock configuration word |

## Verification
Reads are combinational, so register state written at one edge is checked on the falling edge that follows. This is how the one-cycle drop of the send-ready flag after a launch is observed. The shifter loads one cycle after the launch and holds each bit for 16 ticks. With a tick on every second cycle, that is 32 cycles per bit. After seeing the start edge, the bench waits 16 cycles and then samples every 32 cycles, so each sample falls in the centre of a bit. A received byte is flagged in the middle of the stop bit, plus the input synchroniser delay. The bench reads the flag only after the whole stop bit has passed. It uses a 200-cycle silence to confirm that a gated or suppressed frame never starts.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int unsigned DATA_OFS  = 0;
  localparam int unsigned CTRL_OFS  = 4;
  localparam int unsigned CLK_OFS   = 8;
  localparam int unsigned RXV_BIT   = 8;
  localparam int unsigned TXR_BIT   = 9;
  localparam int unsigned MODE_LSB  = 2;
  localparam int unsigned TXF_BIT   = 7;
  localparam int unsigned RXF_BIT   = 8;
  localparam int unsigned OVR_BIT   = 9;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned CNT_W   = $clog2(OVS);
  localparam int unsigned BIT_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   sub_q;
  logic [BIT_W-1:0]   bit_q;
  logic               busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '1;
      sub_q   <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b0;
    end else if (load_i && !busy_q) begin
      shreg_q <= {1'b1, data_i, 1'b0};
      sub_q   <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q && tick_i) begin
      if (sub_q == CNT_W'(OVS - 1)) begin
        sub_q   <= '0;
        // refill with ones so the line rests high after the stop bit
        shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
        if (bit_q == BIT_W'(FRAME_W - 1)) busy_q <= 1'b0;
        else                              bit_q  <= bit_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign tx_o   = shreg_q[0];
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
  import uart_regif_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam int unsigned HALF  = OVS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  rx_state_e              state_q;
  logic [CNT_W-1:0]       sub_q;
  logic [BIT_W-1:0]       bit_q;
  logic [DATA_W-1:0]      shreg_q;
  logic                   done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      sub_q   <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          RX_IDLE: begin
            if (!rx_s) begin
              state_q <= RX_START;
              sub_q   <= '0;
            end
          end
          RX_START: begin
            if (sub_q == CNT_W'(HALF - 1)) begin
              sub_q   <= '0;
              bit_q   <= '0;
              // line must still be low at mid start bit
              state_q <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (sub_q == CNT_W'(OVS - 1)) begin
              sub_q   <= '0;
              shreg_q <= {rx_s, shreg_q[DATA_W-1:1]};
              if (bit_q == BIT_W'(DATA_W - 1)) state_q <= RX_STOP;
              else                             bit_q   <= bit_q + 1'b1;
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (sub_q == CNT_W'(OVS - 1)) begin
              sub_q   <= '0;
              state_q <= RX_IDLE;
              done_q  <= rx_s;
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign data_o = shreg_q;
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STEP_W      = 16,
  parameter int unsigned SCALE_W     = 12,
  parameter int unsigned SCALE_LSB   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              tick_i,
  input  logic              tx_allow_i,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              rx_rdy_o,
  output logic [31:0]       clk_cfg_o
);
  localparam int unsigned MODE_W = 2;

  logic wr_data, wr_ctrl, wr_clk;
  logic tx_launch, tx_load, tx_busy, rx_clr, rx_done;
  logic [DATA_W-1:0] tx_hold, rx_byte, rx_shift_data;
  logic tx_full, rx_valid, overrun_q, tx_force_q, rx_force_q;
  logic [MODE_W-1:0]  mode_q;
  logic [STEP_W-1:0]  step_q;
  logic [SCALE_W-1:0] scale_q;
  logic [31:0] cfg_word;
  logic        unused_wdata;

  assign unused_wdata = ^wdata_i;

  assign wr_data = req_i && we_i && (addr_i == ADDR_W'(DATA_OFS));
  assign wr_ctrl = req_i && we_i && (addr_i == ADDR_W'(CTRL_OFS));
  assign wr_clk  = req_i && we_i && (addr_i == ADDR_W'(CLK_OFS));

  assign tx_launch = wr_data && wdata_i[TXR_BIT] && !tx_full;
  assign tx_load   = tx_full && !tx_busy && (tx_allow_i || tx_force_q);
  assign rx_clr    = wr_data && wdata_i[RXV_BIT];

  // transmit holding register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_hold <= '0;
      tx_full <= 1'b0;
    end else if (tx_launch) begin
      tx_hold <= wdata_i[DATA_W-1:0];
      tx_full <= 1'b1;
    end else if (tx_load) begin
      tx_full <= 1'b0;
    end
  end

  // receive holding register and overrun
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_byte   <= '0;
      rx_valid  <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (rx_done && (!rx_valid || rx_clr)) begin
        rx_byte  <= rx_shift_data;
        rx_valid <= 1'b1;
      end else if (rx_clr) begin
        rx_valid <= 1'b0;
      end
      if (rx_done && rx_valid && !rx_clr) overrun_q <= 1'b1;
      else if (wr_ctrl && wdata_i[OVR_BIT]) overrun_q <= 1'b0;
    end
  end

  // control and clock configuration
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= '0;
      tx_force_q <= 1'b0;
      rx_force_q <= 1'b0;
      step_q     <= '0;
      scale_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q     <= wdata_i[MODE_LSB +: MODE_W];
        tx_force_q <= wdata_i[TXF_BIT];
        rx_force_q <= wdata_i[RXF_BIT];
      end
      if (wr_clk) begin
        step_q  <= wdata_i[STEP_W-1:0];
        scale_q <= wdata_i[SCALE_LSB +: SCALE_W];
      end
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[STEP_W-1:0] = step_q;
    cfg_word[SCALE_LSB +: SCALE_W] = scale_q;
  end
  assign clk_cfg_o = cfg_word;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(DATA_OFS)) begin
      rdata_o[DATA_W-1:0] = rx_byte;
      rdata_o[RXV_BIT]    = rx_valid;
      rdata_o[TXR_BIT]    = !tx_full;
    end else if (addr_i == ADDR_W'(CTRL_OFS)) begin
      rdata_o[MODE_LSB +: MODE_W] = mode_q;
      rdata_o[TXF_BIT] = tx_force_q;
      rdata_o[RXF_BIT] = rx_force_q;
      rdata_o[OVR_BIT] = overrun_q;
    end else if (addr_i == ADDR_W'(CLK_OFS)) begin
      rdata_o = cfg_word;
    end
  end

  assign rx_rdy_o = !rx_valid || rx_force_q;

  uart_tx_shift #(
    .DATA_W (DATA_W),
    .OVS    (OVS)
  ) tx_shift_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .load_i (tx_load),
    .data_i (tx_hold),
    .busy_o (tx_busy),
    .tx_o   (tx_o)
  );

  uart_rx_shift #(
    .DATA_W      (DATA_W),
    .OVS         (OVS),
    .SYNC_STAGES (SYNC_STAGES)
  ) rx_shift_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .rx_i   (rx_i),
    .done_o (rx_done),
    .data_o (rx_shift_data)
  );
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk
  import uart_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              tx_allow_i,
  input logic              tx_full,
  input logic              tx_busy,
  input logic              tx_force_q,
  input logic              rx_valid,
  input logic              rx_done,
  input logic              overrun_q,
  input logic              tx_o
);
  logic data_wr, ctrl_wr;
  assign data_wr = req_i && we_i && (addr_i == ADDR_W'(DATA_OFS));
  assign ctrl_wr = req_i && we_i && (addr_i == ADDR_W'(CTRL_OFS));

  // R2
  launch_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && wdata_i[TXR_BIT] && !tx_full |=> tx_full);

  // R3
  no_strobe_no_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && !wdata_i[TXR_BIT] && !tx_full |=> !tx_full);

  // R4
  idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy && !$past(tx_busy) |-> tx_o);

  // R5
  gated_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy) |-> $past(tx_allow_i || tx_force_q));

  // R6
  valid_from_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid) |-> $past(rx_done));

  // R7
  flag_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid && !(data_wr && wdata_i[RXV_BIT]) |=> rx_valid);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_q && !(ctrl_wr && wdata_i[OVR_BIT]) |=> overrun_q);
endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .tx_allow_i (tx_allow_i),
  .tx_full    (tx_full),
  .tx_busy    (tx_busy),
  .tx_force_q (tx_force_q),
  .rx_valid   (rx_valid),
  .rx_done    (rx_done),
  .overrun_q  (overrun_q),
  .tx_o       (tx_o)
);

// File: tb/uart_regif_tb_top.sv
`timescale 1ns/1ps
module uart_regif_tb_top;
  localparam int BIT_CYC  = 32;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata, clk_cfg;
  logic tick = 1'b0, tx_allow = 1'b1, rx_line = 1'b1;
  logic tx_line, rx_rdy;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  uart_regif dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .tx_allow_i(tx_allow),
    .rx_i(rx_line), .tx_o(tx_line), .rx_rdy_o(rx_rdy), .clk_cfg_o(clk_cfg)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req_tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic expect_frame(input string tag, input logic [7:0] b);
    int waited = 0;
    while (tx_line !== 1'b0 && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    chk({tag, " start edge"}, 32'(tx_line), 32'd0);
    repeat (BIT_CYC / 2) @(negedge clk);
    chk({tag, " start bit"}, 32'(tx_line), 32'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT_CYC) @(negedge clk);
      chk({tag, " data bit"}, 32'(tx_line), 32'(b[i]));
    end
    repeat (BIT_CYC) @(negedge clk);
    chk({tag, " stop bit"}, 32'(tx_line), 32'd1);
    repeat (BIT_CYC) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk);
    rx_line = 1'b0;
    repeat (BIT_CYC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      repeat (BIT_CYC) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (BIT_CYC + 8) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_rd(4'h0, d); chk("R1 data", d, 32'h200);
    bus_rd(4'h4, d); chk("R1 ctrl", d, 32'h0);
    bus_rd(4'h8, d); chk("R1 clk", d, 32'h0);
    chk("R1 tx idle", 32'(tx_line), 32'd1);
  endtask

  task automatic t_no_strobe;
    logic [31:0] d;
    bus_wr(4'h0, 32'h0000_0055);
    bus_rd(4'h0, d); chk("R3 ready kept", 32'(d[9]), 32'd1);
    begin
      int low = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (tx_line !== 1'b1) low++;
      end
      chk("R3 line high", 32'(low), 32'd0);
    end
  endtask

  task automatic t_send;
    logic [31:0] d;
    bus_wr(4'h0, 32'h0000_02A5);
    bus_rd(4'h0, d); chk("R2 ready dropped", 32'(d[9]), 32'd0);
    expect_frame("R4 frame a5", 8'hA5);
    bus_rd(4'h0, d); chk("R2 ready back", 32'(d[9]), 32'd1);
    bus_wr(4'h0, 32'h0000_0201);
    expect_frame("R4 frame 01", 8'h01);
  endtask

  task automatic t_gate;
    logic [31:0] d;
    int low = 0;
    tx_allow = 1'b0;
    bus_wr(4'h0, 32'h0000_023C);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_line !== 1'b1) low++;
    end
    chk("R5 held while gated", 32'(low), 32'd0);
    bus_rd(4'h0, d); chk("R5 ready stays low", 32'(d[9]), 32'd0);
    bus_wr(4'h4, 32'h0000_0080);
    expect_frame("R5 override frame", 8'h3C);
    bus_wr(4'h4, 32'h0);
    tx_allow = 1'b1;
  endtask

  task automatic t_rx;
    logic [31:0] d;
    send_rx(8'hC3);
    bus_rd(4'h0, d); chk("R6 byte and flag", d & 32'h1FF, 32'h1C3);
    chk("R10 rdy low when full", 32'(rx_rdy), 32'd0);
    bus_wr(4'h0, 32'h0000_0000);
    bus_rd(4'h0, d); chk("R7 no-clear write", d & 32'h1FF, 32'h1C3);
    bus_wr(4'h0, 32'h0000_0100);
    bus_rd(4'h0, d); chk("R7 cleared", 32'(d[8]), 32'd0);
    chk("R10 rdy high when empty", 32'(rx_rdy), 32'd1);
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    send_rx(8'h5A);
    send_rx(8'h77);
    bus_rd(4'h0, d); chk("R8 first byte kept", d & 32'h1FF, 32'h15A);
    bus_rd(4'h4, d); chk("R8 overrun set", 32'(d[9]), 32'd1);
    bus_wr(4'h0, 32'h0000_0100);
    bus_rd(4'h4, d); chk("R8 overrun sticky", 32'(d[9]), 32'd1);
    bus_wr(4'h4, 32'h0000_0200);
    bus_rd(4'h4, d); chk("R8 overrun cleared", 32'(d[9]), 32'd0);
  endtask

  task automatic t_glitch;
    logic [31:0] d;
    @(negedge clk);
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_line = 1'b1;
    repeat (BIT_CYC * 11) @(negedge clk);
    bus_rd(4'h0, d); chk("R9 glitch ignored", 32'(d[8]), 32'd0);
    send_rx(8'h81);
    bus_rd(4'h0, d); chk("R9 next frame ok", d & 32'h1FF, 32'h181);
    bus_wr(4'h0, 32'h0000_0100);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    bus_wr(4'h4, 32'h0000_0008);
    bus_rd(4'h4, d); chk("R10 mode modem side", d, 32'h8);
    bus_wr(4'h4, 32'h0000_0184);
    bus_rd(4'h4, d); chk("R10 overrides and mode", d, 32'h184);
    send_rx(8'h10);
    chk("R10 forced rdy", 32'(rx_rdy), 32'd1);
    bus_wr(4'h0, 32'h0000_0100);
    bus_wr(4'h4, 32'h0);
  endtask

  task automatic t_clk;
    logic [31:0] d;
    bus_wr(4'h8, 32'hFFFF_FFFF);
    bus_rd(4'h8, d); chk("R11 field mask", d, 32'h0FFF_FFFF);
    bus_wr(4'h8, 32'h0123_4567);
    bus_rd(4'h8, d); chk("R11 value", d, 32'h0123_4567);
    chk("R11 output", clk_cfg, 32'h0123_4567);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    bus_wr(4'hC, 32'hFFFF_FFFF);
    bus_rd(4'hC, d); chk("R12 reads zero", d, 32'h0);
    bus_rd(4'h8, d); chk("R12 clk untouched", d, 32'h0123_4567);
    bus_rd(4'h4, d); chk("R12 ctrl untouched", d, 32'h0);
    bus_rd(4'h0, d); chk("R12 data untouched", d & 32'h300, 32'h200);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_strobe();
    t_send();
    t_gate();
    t_rx();
    t_overrun();
    t_glitch();
    t_ctrl();
    t_clk();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule